// File: doc/BRIEF.md
# Store Completion Tracker with Invalidate Acknowledgement Counting

This block sits between a single processor's memory request port and a coherence fabric that joins several nodes. It gives stores atomic visibility. When a store is accepted, the block sends an invalidate strobe to every node except its own, together with the store address. It then gathers acknowledgements in one bit per node. The store counts as complete only when every other node has answered. Acknowledgements may come back in any order, one at a time or several in the same cycle.

Requests are taken one at a time in program order. While a store waits for its acknowledgements, the request port is not ready, so the next operation waits. This applies in particular to a read that would observe the pending value. The read is taken once the store has completed, so every node has seen a write before any read returns it. Because only one store can be outstanding, two stores to the same address always become visible in the order they were accepted. A read finishes one cycle after it is accepted. It returns the data of the most recently completed store when its address matches that store's address. An acknowledgement that arrives when it is not wanted is discarded and sets a sticky error flag.

Top module: `wat_tracker`

## Requirements
- R1: In the cycle after a store is accepted (reqValid and reqReady high with reqWrite=1), invValid has bit i set for every node i except SELF_ID and invAddr equals the store address. In the following cycle invValid is all zero again.
- R2: A pending store completes with donePulse=1 and doneWrite=1 in the cycle after the clock edge at which the last missing acknowledgement from the other nodes is sampled. Acknowledgements may arrive in any order and in any grouping, and completion never happens earlier.
- R3: reqReady is 0 from the cycle after a store is accepted until that store completes. reqReady is 1 in the completion cycle.
- R4: A read held on the request port while a store to the same address is pending is not accepted, so no donePulse is raised for it. Once the store completes, the read is accepted and returns the newly stored data.
- R5: A read completes in the cycle after it is accepted, with donePulse=1 and doneWrite=0. If its address equals the address of the most recently completed store, rdHit=1 and rdData is that store's data. Otherwise rdHit=0 and rdData=0.
- R6: An acknowledgement from a node that has already answered the pending store, or any acknowledgement while no store is pending, does not count toward completion and sets errDup. errDup stays 1 until reset.
- R7: An acknowledgement on the ackIn line of SELF_ID is ignored. It does not help complete a store and does not set errDup.
- R8: After reset, reqReady=1, donePulse=0, invValid=0, errDup=0 and rdHit=0.
- R9: Two stores to the same address complete in the order they were accepted. A later read of that address returns the second store's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Request accepted on this edge when high together with reqValid |
| reqWrite | input | 1 | 1 = store, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | DATA_W | Store data |
| invValid | output | NUM_NODES | One-cycle invalidate strobe per node |
| invAddr | output | ADDR_W | Address carried by the invalidate |
| ackIn | input | NUM_NODES | Per-node invalidate acknowledgement pulses |
| donePulse | output | 1 | One-cycle completion of the current operation |
| doneWrite | output | 1 | Qualifies donePulse: 1 when a store completed |
| rdData | output | DATA_W | Read result |
| rdHit | output | 1 | Read address matched the last completed store |
| errDup | output | 1 | Sticky unexpected-acknowledgement flag |

## Verification
The bound checker keeps its own copy of the acknowledgement set and of the pending state, derived only from the ports. Against that copy it checks every cycle that store completion follows a full set of acknowledgements, that the port stays stalled while a store is pending, that invalidates go only to the other nodes and only after an accepted store, that reads finish in one cycle, and that the error flag never clears. Properties cannot cover which value a read returns, how a stalled read behaves once it is released, same-address ordering, or the fact that the own node's line is ignored. The bench covers these by driving every arrival order of the three remote acknowledgements, grouped arrivals, duplicate and self acknowledgements, and read hit and miss sequences, and by comparing against values it computes itself.

// File: rtl/wat_pkg.sv
package wat_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} watState_t;

  typedef struct packed {
    logic issueWr;
    logic issueRd;
    logic finishWr;
  } watStrobes_t;
endpackage

// File: rtl/wat_ctrl.sv
module wat_ctrl
  import wat_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int SELF_ID   = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [NUM_NODES-1:0] ackIn,
  output logic                 reqReady,
  output watStrobes_t          strb,
  output logic                 donePulse,
  output logic                 doneWrite,
  output logic                 errDup
);
  localparam logic [NUM_NODES-1:0] SELF_MASK  = {{(NUM_NODES-1){1'b0}}, 1'b1} << SELF_ID;
  localparam logic [NUM_NODES-1:0] OTHER_MASK = ~SELF_MASK;

  watState_t             state;
  logic [NUM_NODES-1:0]  ackSeen;
  logic [NUM_NODES-1:0]  ackUseful;
  logic [NUM_NODES-1:0]  ackMerged;
  logic                  accept;
  logic                  dupHit;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    accept        = reqValid && reqReady;
    strb.issueWr  = accept && reqWrite;
    strb.issueRd  = accept && !reqWrite;
    ackUseful     = ackIn & OTHER_MASK;
    ackMerged     = ackSeen | ackUseful;
    strb.finishWr = (state == ST_WAIT) && (&ackMerged);
    // while idle every bit of ackSeen is set, so any remote ack counts here
    dupHit        = |(ackUseful & ackSeen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackSeen   <= '1;
      donePulse <= 1'b0;
      doneWrite <= 1'b0;
      errDup    <= 1'b0;
    end else begin
      if (strb.issueWr) begin
        state   <= ST_WAIT;
        ackSeen <= SELF_MASK;
      end else begin
        ackSeen <= ackMerged;
        if (strb.finishWr) state <= ST_IDLE;
      end
      donePulse <= strb.finishWr | strb.issueRd;
      doneWrite <= strb.finishWr;
      if (dupHit) errDup <= 1'b1;
    end
  end
endmodule

// File: rtl/wat_dpath.sv
module wat_dpath
  import wat_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int SELF_ID   = 0,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  watStrobes_t          strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  output logic [NUM_NODES-1:0] invValid,
  output logic [ADDR_W-1:0]    invAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdHit
);
  localparam logic [NUM_NODES-1:0] SELF_MASK = {{(NUM_NODES-1){1'b0}}, 1'b1} << SELF_ID;

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic              lastValid;
  logic              addrMatch;

  assign invAddr   = pendAddr;
  assign addrMatch = lastValid && (reqAddr == lastAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendData  <= '0;
      lastAddr  <= '0;
      lastData  <= '0;
      lastValid <= 1'b0;
      invValid  <= '0;
      rdData    <= '0;
      rdHit     <= 1'b0;
    end else begin
      invValid <= strb.issueWr ? ~SELF_MASK : '0;
      if (strb.issueWr) begin
        pendAddr <= reqAddr;
        pendData <= reqData;
      end
      if (strb.finishWr) begin
        lastAddr  <= pendAddr;
        lastData  <= pendData;
        lastValid <= 1'b1;
      end
      if (strb.issueRd) begin
        rdHit  <= addrMatch;
        rdData <= addrMatch ? lastData : '0;
      end
    end
  end
endmodule

// File: rtl/wat_tracker.sv
module wat_tracker
  import wat_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int SELF_ID   = 0,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  output logic [NUM_NODES-1:0] invValid,
  output logic [ADDR_W-1:0]    invAddr,
  input  logic [NUM_NODES-1:0] ackIn,
  output logic                 donePulse,
  output logic                 doneWrite,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdHit,
  output logic                 errDup
);
  watStrobes_t strb;

  wat_ctrl #(.NUM_NODES(NUM_NODES), .SELF_ID(SELF_ID)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ackIn(ackIn), .reqReady(reqReady), .strb(strb),
    .donePulse(donePulse), .doneWrite(doneWrite), .errDup(errDup)
  );

  wat_dpath #(.NUM_NODES(NUM_NODES), .SELF_ID(SELF_ID),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqData(reqData),
    .invValid(invValid), .invAddr(invAddr), .rdData(rdData), .rdHit(rdHit)
  );
endmodule

// File: rtl/wat_tracker_chk.sv
module wat_tracker_chk #(
  parameter int NUM_NODES = 4,
  parameter int SELF_ID   = 0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 reqWrite,
  input logic [NUM_NODES-1:0] invValid,
  input logic [NUM_NODES-1:0] ackIn,
  input logic                 donePulse,
  input logic                 doneWrite,
  input logic                 errDup
);
  localparam logic [NUM_NODES-1:0] SELF_MASK = {{(NUM_NODES-1){1'b0}}, 1'b1} << SELF_ID;

  logic [NUM_NODES-1:0] seenChk;
  logic                 pendChk;
  logic                 wrAcc;

  assign wrAcc = reqValid && reqReady && reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenChk <= '1;
      pendChk <= 1'b0;
    end else begin
      if (wrAcc) seenChk <= SELF_MASK;
      else       seenChk <= seenChk | ackIn;
      if (wrAcc) pendChk <= 1'b1;
      else if (donePulse && doneWrite) pendChk <= 1'b0;
    end
  end

  AST_DONE_AFTER_ALL_ACKS: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && doneWrite) |-> $past(&(seenChk | ackIn)));  // R2

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (pendChk && !(donePulse && doneWrite)) |-> !reqReady);  // R3

  AST_INV_AFTER_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (invValid != '0) |-> (invValid == ~SELF_MASK));  // R1

  AST_STORE_BROADCASTS: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> (invValid == ~SELF_MASK));  // R1

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (donePulse && !doneWrite));  // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errDup |=> errDup);  // R6
endmodule

bind wat_tracker wat_tracker_chk #(.NUM_NODES(NUM_NODES), .SELF_ID(SELF_ID)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .invValid(invValid), .ackIn(ackIn),
  .donePulse(donePulse), .doneWrite(doneWrite), .errDup(errDup)
);

// File: tb/wat_tracker_tb_top.sv
module wat_tracker_tb_top;
  localparam int NN = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [NN-1:0] OTHERS = 4'b1110;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [NN-1:0] invValid;
  logic [AW-1:0] invAddr;
  logic [NN-1:0] ackIn = '0;
  logic          donePulse, doneWrite, rdHit, errDup;
  logic [DW-1:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wat_tracker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .invValid(invValid), .invAddr(invAddr), .ackIn(ackIn),
    .donePulse(donePulse), .doneWrite(doneWrite), .rdData(rdData),
    .rdHit(rdHit), .errDup(errDup)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue a store and check the broadcast cycle; returns at that negedge
  task automatic startWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk(invValid == OTHERS, "R1 inv mask", 32'(invValid), 32'(OTHERS));
    chk(invAddr == a, "R1 inv addr", 32'(invAddr), 32'(a));
    chk(!reqReady, "R3 stall", 32'(reqReady), 0);
  endtask

  // apply one ack vector for one cycle, then check the outcome
  task automatic ackStep(input logic [NN-1:0] v, input bit expDone);
    ackIn = v;
    @(negedge clk);
    ackIn = '0;
    chk(invValid == '0, "R1 inv one cycle", 32'(invValid), 0);
    chk(donePulse == expDone, "R2 done timing", 32'(donePulse), 32'(expDone));
    chk(reqReady == expDone, "R3 ready", 32'(reqReady), 32'(expDone));
    if (expDone) chk(doneWrite, "R2 doneWrite", 32'(doneWrite), 1);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input bit expHit,
                        input logic [DW-1:0] expData, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(donePulse && !doneWrite, {req, " read done"}, {donePulse, doneWrite}, 2);
    chk(rdHit == expHit, {req, " rdHit"}, 32'(rdHit), 32'(expHit));
    chk(rdData == expData, {req, " rdData"}, rdData, expData);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int seq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(reqReady, "R8 ready", 32'(reqReady), 1);
    chk(!donePulse, "R8 done", 32'(donePulse), 0);
    chk(invValid == '0, "R8 inv", 32'(invValid), 0);
    chk(!errDup, "R8 err", 32'(errDup), 0);
    chk(!rdHit, "R8 hit", 32'(rdHit), 0);
    doRead(16'h0005, 1'b0, '0, "R5 miss empty");

    // R2 every arrival order of the three remote acks
    seq = 0;
    for (int a = 1; a < NN; a++)
      for (int b = 1; b < NN; b++)
        for (int c = 1; c < NN; c++)
          if (a != b && b != c && a != c) begin
            startWrite(16'(16'h0100 + seq), 32'hA000_0000 + 32'(seq));
            ackStep(4'(1 << a), 1'b0);
            ackStep('0, 1'b0);
            ackStep(4'(1 << b), 1'b0);
            ackStep(4'(1 << c), 1'b1);
            @(negedge clk);
            chk(!donePulse, "R2 single pulse", 32'(donePulse), 0);
            doRead(16'(16'h0100 + seq), 1'b1, 32'hA000_0000 + 32'(seq), "R5 hit");
            seq++;
          end

    // R2 grouped arrivals
    startWrite(16'h0200, 32'h1234_5678);
    ackStep(OTHERS, 1'b1);
    startWrite(16'h0201, 32'h8765_4321);
    ackStep(4'b0110, 1'b0);
    ackStep(4'b1000, 1'b1);
    doRead(16'h0200, 1'b0, '0, "R5 miss stale");

    // R7 own line ignored
    startWrite(16'h0300, 32'h0000_0333);
    ackStep(4'b0001, 1'b0);
    ackStep(4'b0111, 1'b0);
    chk(!errDup, "R7 no err", 32'(errDup), 0);
    ackStep(4'b1000, 1'b1);
    chk(!errDup, "R7 no err after", 32'(errDup), 0);

    // R4 read of pending address held until completion
    startWrite(16'h0400, 32'hCAFE_0001);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'h0400;
    ackStep(4'b0110, 1'b0);
    ackStep('0, 1'b0);
    ackStep(4'b1000, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(donePulse && !doneWrite, "R4 read done", {donePulse, doneWrite}, 2);
    chk(rdHit, "R4 hit", 32'(rdHit), 1);
    chk(rdData == 32'hCAFE_0001, "R4 new data", rdData, 32'hCAFE_0001);

    // R9 same address serialized
    startWrite(16'h0500, 32'h0000_0001);
    ackStep(OTHERS, 1'b1);
    startWrite(16'h0500, 32'h0000_0002);
    ackStep(4'b1100, 1'b0);
    ackStep(4'b0010, 1'b1);
    doRead(16'h0500, 1'b1, 32'h0000_0002, "R9 last value");

    // R6 duplicate ack
    startWrite(16'h0600, 32'h0000_0666);
    ackStep(4'b0010, 1'b0);
    chk(!errDup, "R6 before dup", 32'(errDup), 0);
    ackStep(4'b0010, 1'b0);
    chk(errDup, "R6 dup sets err", 32'(errDup), 1);
    ackStep(4'b1100, 1'b1);
    chk(errDup, "R6 sticky", 32'(errDup), 1);
    doRead(16'h0600, 1'b1, 32'h0000_0666, "R6 data intact");
    chk(errDup, "R6 sticky later", 32'(errDup), 1);

    // R6 ack while idle, after a reset
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!errDup, "R8 err cleared", 32'(errDup), 0);
    ackIn = 4'b0100;
    @(negedge clk);
    ackIn = '0;
    chk(errDup, "R6 idle ack", 32'(errDup), 1);
    chk(!donePulse, "R6 idle no done", 32'(donePulse), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule